// File: doc/BRIEF.md
# Keepalive Idle Timer

This block watches a reliable segment link for silence and acts on it according to the role of the local end. An integer count of idle time units is kept while the connection is up. Each unit is marked by a one-cycle tick from a shared prescaler. A 16-bit timeout value, expressed in those same units, sets the limit.

At the server end, every received segment restarts the count. This covers data, acknowledgement and keepalive segments alike. If the full timeout passes with nothing received, the block raises a close flag, which doubles as the "keepalive missed" status bit. At the client end, every transmitted segment restarts the count. Once half the timeout (rounded down) has passed with nothing sent, the block pulses a request to send a keepalive segment.

Segment generation and connection teardown belong to the neighbouring logic; this block only supplies the two decisions. All pins are plain control and status levels or pulses; there is no data flow and so no handshake.

Top module: `keepalive_timer`

## Requirements
- R1: After reset, `send_keepalive` and `peer_lost` are 0.
- R2: In the server role (`role_server`=1), with `link_up` high and no `seg_rx`, `peer_lost` rises on the clock edge that samples the N-th `unit_tick`, where N is `idle_limit`; it is low after N-1 ticks.
- R3: In the server role, a `seg_rx` pulse restarts the count from zero; `seg_tx` has no effect on the count.
- R4: In the client role (`role_server`=0), `send_keepalive` is a one-cycle pulse on the edge that samples the M-th idle tick, where M = floor(`idle_limit`/2); `seg_rx` has no effect on the count.
- R5: After a keepalive request, further ticks produce no new request until a `seg_tx` restarts the count; counting then starts again from zero.
- R6: A restart pulse in the same cycle as a tick wins: the count becomes zero and no expiry occurs in that cycle.
- R7: While `link_up` is low, the count is held at zero, ticks are ignored, and both outputs are 0 one edge later.
- R8: `peer_lost` stays high while `link_up` stays high, even if segments arrive later. The client role never raises `peer_lost`, and the server role never raises `send_keepalive`.
- R9: A threshold of zero disables expiry. This happens with `idle_limit`=0 in either role, and with `idle_limit`=1 in the client role.
- R10: `unit_code` is a constant equal to the negative base-10 exponent of the time unit in seconds, set by the parameter `UNIT_EXP` (default 6, meaning microseconds).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| role_server | input | 1 | 1 = server role, 0 = client role |
| link_up | input | 1 | Connection active |
| unit_tick | input | 1 | One-cycle pulse per time unit |
| seg_rx | input | 1 | One-cycle pulse per received segment |
| seg_tx | input | 1 | One-cycle pulse per transmitted segment |
| idle_limit | input | 16 | Keepalive timeout in time units |
| send_keepalive | output | 1 | One-cycle request to transmit a keepalive segment (client) |
| peer_lost | output | 1 | Keepalive missed, connection must close (server), sticky |
| unit_code | output | 8 | Time unit code: negative base-10 exponent |

## Verification
The embedded assertions check the following on every cycle:
- a restart always empties the count;
- the count is frozen when there is no tick;
- a request never lasts two cycles;
- each output only follows an expiry in its own role;
- the close flag holds while the link is up;
- a dropped link clears everything.

Only the bench scenarios can show the exact tick on which each output fires for a given limit. They also show the halving and rounding in the client role, the disabled thresholds, and the priority of a restart over a tick. The bench compares against a cycle model built from the requirements, under random roles, limits and traffic.

// File: rtl/kat_pkg.sv
package kat_pkg;
  typedef enum logic {
    ROLE_CLIENT = 1'b0,
    ROLE_SERVER = 1'b1
  } kat_role_e;
endpackage

// File: rtl/kat_threshold.sv
module kat_threshold
  import kat_pkg::*;
#(
  parameter int W = 16
) (
  input  kat_role_e      role,
  input  logic [W-1:0]   timeout,
  output logic [W-1:0]   limit,
  output logic           armed
);
  localparam int CLIENT_SHIFT = 1;

  always_comb begin
    if (role == ROLE_SERVER) limit = timeout;
    else                     limit = timeout >> CLIENT_SHIFT;
    armed = (limit != '0);
  end
endmodule

// File: rtl/kat_idle_counter.sv
module kat_idle_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         tick,
  input  logic         restart,
  input  logic [W-1:0] limit,
  input  logic         armed,
  output logic         expire,
  output logic [W-1:0] count
);
  localparam int WX = W + 1;

  logic [WX-1:0] next_cnt;
  logic          below;
  logic          advance;

  always_comb begin
    next_cnt = {1'b0, count} + WX'(1);
    below    = armed && (count < limit);
    advance  = active && tick && !restart && below;
    expire   = advance && (next_cnt == {1'b0, limit});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            count <= '0;
    else if (!active)      count <= '0;
    else if (restart)      count <= '0;
    else if (advance)      count <= next_cnt[W-1:0];
  end

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (restart || !active) |=> (count == '0)); // R6
  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick && !restart) |=> $stable(count)); // R5
endmodule

// File: rtl/kat_event_out.sv
module kat_event_out
  import kat_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      active,
  input  kat_role_e role,
  input  logic      expire,
  output logic      req_pulse,
  output logic      lost_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_pulse <= 1'b0;
      lost_flag <= 1'b0;
    end else if (!active) begin
      req_pulse <= 1'b0;
      lost_flag <= 1'b0;
    end else begin
      req_pulse <= expire && (role == ROLE_CLIENT);
      if (expire && role == ROLE_SERVER) lost_flag <= 1'b1;
    end
  end

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_pulse |=> !req_pulse); // R5
  AST_REQ_CLIENT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_pulse) |-> ($past(role) == ROLE_CLIENT && $past(expire))); // R4
  AST_LOST_SERVER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost_flag) |-> ($past(role) == ROLE_SERVER && $past(expire))); // R8
  AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_flag && active) |=> lost_flag); // R8
  AST_DOWN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!lost_flag && !req_pulse)); // R7
endmodule

// File: rtl/keepalive_timer.sv
module keepalive_timer
  import kat_pkg::*;
#(
  parameter int TMO_W    = 16,
  parameter int UNIT_EXP = 6,
  parameter int CODE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              role_server,
  input  logic              link_up,
  input  logic              unit_tick,
  input  logic              seg_rx,
  input  logic              seg_tx,
  input  logic [TMO_W-1:0]  idle_limit,
  output logic              send_keepalive,
  output logic              peer_lost,
  output logic [CODE_W-1:0] unit_code
);
  kat_role_e        role;
  logic [TMO_W-1:0] limit;
  logic             armed;
  logic             restart;
  logic             expire;
  logic [TMO_W-1:0] count;

  assign role      = role_server ? ROLE_SERVER : ROLE_CLIENT;
  assign restart   = (role == ROLE_SERVER) ? seg_rx : seg_tx;
  assign unit_code = CODE_W'(UNIT_EXP);

  kat_threshold #(.W(TMO_W)) u_thr (
    .role    (role),
    .timeout (idle_limit),
    .limit   (limit),
    .armed   (armed)
  );

  kat_idle_counter #(.W(TMO_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (link_up),
    .tick    (unit_tick),
    .restart (restart),
    .limit   (limit),
    .armed   (armed),
    .expire  (expire),
    .count   (count)
  );

  kat_event_out u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (link_up),
    .role      (role),
    .expire    (expire),
    .req_pulse (send_keepalive),
    .lost_flag (peer_lost)
  );

  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !peer_lost) |=> !$rose(peer_lost) && !send_keepalive); // R9
endmodule

// File: tb/keepalive_timer_test.sv
module keepalive_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic role_server = 1'b0, link_up = 1'b0, unit_tick = 1'b0, seg_rx = 1'b0, seg_tx = 1'b0;
  logic [W-1:0] idle_limit = '0;
  logic send_keepalive, peer_lost;
  logic [7:0] unit_code;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  int m_cnt = 0;
  bit m_req = 0, m_lost = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keepalive_timer uut (
    .clk(clk), .rst_n(rst_n), .role_server(role_server), .link_up(link_up),
    .unit_tick(unit_tick), .seg_rx(seg_rx), .seg_tx(seg_tx), .idle_limit(idle_limit),
    .send_keepalive(send_keepalive), .peer_lost(peer_lost), .unit_code(unit_code)
  );

  function automatic int thr_of(bit srv, int tmo);
    return srv ? tmo : tmo / 2;
  endfunction

  task automatic chk(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_step();
    int t;
    bit rs, ex;
    t  = thr_of(role_server, int'(idle_limit));
    rs = role_server ? seg_rx : seg_tx;
    if (!link_up) begin
      m_cnt = 0; m_req = 0; m_lost = 0;
    end else begin
      ex = unit_tick && !rs && (m_cnt < t) && (m_cnt + 1 == t);
      m_req = ex && !role_server;
      if (ex && role_server) m_lost = 1;
      if (rs) m_cnt = 0;
      else if (unit_tick && m_cnt < t) m_cnt = m_cnt + 1;
    end
  endtask

  // one cycle: drive at negedge, clock, compare at next negedge
  task automatic cyc(bit tk, bit rx, bit tx, string tag);
    unit_tick = tk; seg_rx = rx; seg_tx = tx;
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(send_keepalive, m_req, {tag, " send_keepalive"});
    chk(peer_lost, m_lost, {tag, " peer_lost"});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk(send_keepalive, 0, "R1 reset send_keepalive");
    chk(peer_lost, 0, "R1 reset peer_lost");
    rst_n = 1'b1;
    @(negedge clk);
    // R10 unit code
    chk(unit_code, 6, "R10 unit_code");

    // R2 server, limit 5
    role_server = 1; idle_limit = 5; link_up = 1;
    cyc(0, 0, 0, "R2 idle");
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, "R2 tick");
    chk(peer_lost, 0, "R2 after 4 ticks");
    cyc(1, 0, 0, "R2 fifth");
    chk(peer_lost, 1, "R2 after 5 ticks");
    // R8 sticky despite rx
    cyc(0, 1, 0, "R8 rx after lost");
    chk(peer_lost, 1, "R8 sticky");
    // R7 drop link
    link_up = 0;
    cyc(1, 0, 0, "R7 down");
    chk(peer_lost, 0, "R7 cleared");
    link_up = 1;

    // R3 rx restarts, tx does not
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, "R3 pre");
    cyc(0, 1, 0, "R3 rx");
    for (int i = 0; i < 4; i++) cyc(1, 0, 1, "R3 tx ignored");
    chk(peer_lost, 0, "R3 restarted by rx");
    cyc(1, 0, 0, "R3 fifth after rx");
    chk(peer_lost, 1, "R3 expiry after restart");
    link_up = 0; cyc(0, 0, 0, "R7 down2"); link_up = 1;

    // R4 client, limit 9 -> 4 ticks
    role_server = 0; idle_limit = 9;
    for (int i = 0; i < 3; i++) cyc(1, 1, 0, "R4 tick rx ignored");
    chk(send_keepalive, 0, "R4 before half");
    cyc(1, 0, 0, "R4 fourth");
    chk(send_keepalive, 1, "R4 pulse");
    cyc(0, 0, 0, "R4 one cycle");
    chk(send_keepalive, 0, "R4 pulse ended");
    // R5 no repeat without tx
    for (int i = 0; i < 10; i++) cyc(1, 0, 0, "R5 no repeat");
    chk(peer_lost, 0, "R8 client no lost");
    cyc(0, 0, 1, "R5 tx");
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, "R5 recount");
    // R6 tick plus tx same cycle
    cyc(1, 0, 1, "R6 tick+tx");
    chk(send_keepalive, 0, "R6 restart wins");
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, "R6 recount");
    chk(send_keepalive, 0, "R6 count from zero");
    cyc(1, 0, 0, "R6 fourth");
    chk(send_keepalive, 1, "R6 pulse after restart");

    // R9 disabled thresholds
    link_up = 0; cyc(0, 0, 0, "R7 down3"); link_up = 1;
    idle_limit = 1;
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, "R9 client limit 1");
    chk(send_keepalive, 0, "R9 client disabled");
    role_server = 1; idle_limit = 0;
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, "R9 server limit 0");
    chk(peer_lost, 0, "R9 server disabled");

    // random phase against model (R2 R3 R4 R5 R6 R7 R8)
    for (int blk = 0; blk < 60; blk++) begin
      role_server = $urandom_range(0, 1);
      idle_limit  = W'($urandom_range(0, 20));
      link_up = 0; cyc(0, 0, 0, "R7 rnd down"); link_up = 1;
      for (int i = 0; i < 60; i++) begin
        if ($urandom_range(0, 49) == 0) link_up = ~link_up;
        cyc($urandom_range(0, 2) != 0, $urandom_range(0, 14) == 0,
            $urandom_range(0, 14) == 0, "R8 random");
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule